// File: doc/BRIEF.md
# IDE Programmed-I/O Register Access Sequencer

This block carries out one 16-bit programmed-I/O transfer to or from a register of an IDE/ATA device per request. The host presents a request with a direction flag, a device register address and, for a write, a data word. While the block is idle it accepts the request. It then drives a fixed series of steps on the device side, one step per clock. The steps are an address step, a preparation step, a strobe window of `STRB_STEPS` clocks, and a trailing recovery step. After the last step the block raises a one-clock completion pulse. For a read, the captured word is returned with that pulse.

One data latch serves both directions. A write loads the host word into it, and the latch drives the device data lines while the output enable is high. A read samples the device data lines into the latch in the final clock of the read strobe, while the strobe is still active. The pad driver outside the block floats the data lines whenever the output enable is low. The device strobes are active low.

Top module: `ide_pio_seq`

## Requirements
- R1: During reset and after it, with no request, `req_ready` is 1, `ide_rd_n` and `ide_wr_n` are 1, and `ide_addr_en`, `ide_dout_en` and `rsp_done` are 0.
- R2: A request is accepted only in a cycle where `req_ready` is 1 and `req_valid` is 1. While a transfer is running, `req_ready` is 0 and `req_valid` has no effect on any output.
- R3: In the first clock after acceptance (step 1), `ide_addr_en` is 1 for exactly that clock. `ide_addr` equals the accepted address from step 1 through the recovery step.
- R4: For a read, step 2 drives nothing. `ide_rd_n` is then 0 for exactly `STRB_STEPS` consecutive clocks (default 3), and `ide_dout_en` stays 0 throughout.
- R5: For a read, the word on `ide_din` in the last clock of the read strobe is the value of `rsp_rdata` in the `rsp_done` cycle. Words present in other clocks are not used.
- R6: For a write, `ide_dout_en` is 1 from step 2 through the last strobe clock, with `ide_dout` equal to the accepted write word. `ide_wr_n` is 0 for exactly `STRB_STEPS` clocks after step 2.
- R7: The clock after the strobe window is a recovery step with every device output inactive. `rsp_done` is 1 for exactly the next clock, and `req_ready` returns to 1 in the clock after that.
- R8: `ide_rd_n` and `ide_wr_n` are never 0 in the same clock.
- R9: The request fields are captured at acceptance. Changes to `req_write`, `req_addr` or `req_wdata` during a transfer do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Device register address (chip selects plus register index) |
| req_wdata | input | DATA_W | Word to write |
| req_ready | output | 1 | Block idle, request will be taken |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read word, valid with `rsp_done` after a read |
| ide_addr | output | ADDR_W | Device register address |
| ide_addr_en | output | 1 | Address step enable |
| ide_rd_n | output | 1 | Device read strobe, active low |
| ide_wr_n | output | 1 | Device write strobe, active low |
| ide_dout_en | output | 1 | Data-line output enable |
| ide_dout | output | DATA_W | Word driven to the data lines |
| ide_din | input | DATA_W | Word sampled from the data lines |

## Verification
The assertions look only at the block's outputs. They take for granted that reset is held long enough for the internal reset synchronizer to settle, and that `STRB_STEPS` is at least 1. The stimulus keeps `req_valid` low for several clocks after reset release. Beyond that, it places no constraint on `req_valid` during a transfer: it toggles the request inputs with altered fields on purpose, so that the ignore behaviour is exercised. The device model changes `ide_din` in every strobe clock, so that a capture in the wrong clock shows up in the returned word.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_PREP = 3'd2,
    ST_STRB = 3'd3,
    ST_TAIL = 3'd4,
    ST_DONE = 3'd5
  } step_e;

endpackage

// File: rtl/ide_pio_rst_sync.sv
module ide_pio_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;

  generate
    genvar g;
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[LAST];

endmodule

// File: rtl/ide_pio_ctrl.sv
module ide_pio_ctrl
  import ide_pio_pkg::*;
#(
  parameter int STRB_STEPS = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  logic  req_write,
  output step_e step,
  output logic  wr_op,
  output logic  accept,
  output logic  cap_rd
);

  localparam int CW = (STRB_STEPS > 1) ? $clog2(STRB_STEPS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STRB_STEPS - 1);

  step_e         step_q, step_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q;
  logic          strb_last;

  assign strb_last = (step_q == ST_STRB) && (cnt_q == CNT_LAST);
  assign accept    = (step_q == ST_IDLE) && req_valid;
  assign cap_rd    = strb_last && !wr_q;

  // next-step logic
  always_comb begin
    step_d = step_q;
    cnt_d  = cnt_q;
    case (step_q)
      ST_IDLE: if (req_valid) step_d = ST_ADDR;
      ST_ADDR: step_d = ST_PREP;
      ST_PREP: begin
        step_d = ST_STRB;
        cnt_d  = '0;
      end
      ST_STRB: begin
        if (cnt_q == CNT_LAST) step_d = ST_TAIL;
        else                   cnt_d  = cnt_q + 1'b1;
      end
      ST_TAIL: step_d = ST_DONE;
      ST_DONE: step_d = ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      cnt_q  <= '0;
    end else begin
      step_q <= step_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_q <= 1'b0;
    else if (accept) wr_q <= req_write;
  end

  assign step  = step_q;
  assign wr_op = wr_q;

endmodule

// File: rtl/ide_pio_datapath.sv
module ide_pio_datapath #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cap_rd,
  input  logic [DATA_W-1:0] ide_din,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] latch_q
);

  logic              latch_en;
  logic [DATA_W-1:0] latch_d;

  assign latch_en = (accept && req_write) || cap_rd;
  assign latch_d  = cap_rd ? ide_din : req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int STRB_STEPS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ide_addr,
  output logic              ide_addr_en,
  output logic              ide_rd_n,
  output logic              ide_wr_n,
  output logic              ide_dout_en,
  output logic [DATA_W-1:0] ide_dout,
  input  logic [DATA_W-1:0] ide_din
);

  logic              rst_n_int;
  step_e             step;
  logic              wr_op;
  logic              accept;
  logic              cap_rd;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] latch_q;

  ide_pio_rst_sync #(.SYNC_STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ide_pio_ctrl #(.STRB_STEPS(STRB_STEPS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .req_write (req_write),
    .step      (step),
    .wr_op     (wr_op),
    .accept    (accept),
    .cap_rd    (cap_rd)
  );

  ide_pio_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cap_rd    (cap_rd),
    .ide_din   (ide_din),
    .addr_q    (addr_q),
    .latch_q   (latch_q)
  );

  // output decode, all taken straight from the step register
  assign req_ready   = (step == ST_IDLE);
  assign rsp_done    = (step == ST_DONE);
  assign rsp_rdata   = latch_q;
  assign ide_addr    = addr_q;
  assign ide_addr_en = (step == ST_ADDR);
  assign ide_rd_n    = !((step == ST_STRB) && !wr_op);
  assign ide_wr_n    = !((step == ST_STRB) && wr_op);
  assign ide_dout_en = wr_op && ((step == ST_PREP) || (step == ST_STRB));
  assign ide_dout    = latch_q;

endmodule

// File: rtl/ide_pio_chk.sv
module ide_pio_chk #(
  parameter int ADDR_W     = 5,
  parameter int STRB_STEPS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] ide_addr,
  input logic              ide_addr_en,
  input logic              ide_rd_n,
  input logic              ide_wr_n,
  input logic              ide_dout_en
);

  localparam int LW = $clog2(STRB_STEPS + 2);

  logic [LW-1:0] low_cnt;
  logic          strb_act;

  assign strb_act = !ide_rd_n || !ide_wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= '0;
    else if (strb_act) low_cnt <= low_cnt + 1'b1;
    else               low_cnt <= '0;
  end

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_rd_n && !ide_wr_n));                                          // R8

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_rd_n |-> !ide_dout_en);                                         // R4

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ide_addr_en || strb_act || ide_dout_en || rsp_done) |-> !req_ready); // R2

  AST_ADDR_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ide_addr_en |=> !ide_addr_en);                                       // R3

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_act && $past(strb_act)) |-> $stable(ide_addr));                // R3

  AST_RD_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ide_rd_n) |-> $past(ide_addr_en, 2));                          // R4

  AST_WR_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ide_wr_n) |-> $past(ide_dout_en));                             // R6

  AST_STRB_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ide_rd_n) || $rose(ide_wr_n)) |-> (low_cnt == LW'(STRB_STEPS))); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));                              // R7

  AST_TAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_done) |-> $past(!strb_act && !ide_dout_en && !ide_addr_en)); // R7

endmodule

bind ide_pio_seq ide_pio_chk #(
  .ADDR_W     (ADDR_W),
  .STRB_STEPS (STRB_STEPS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_done    (rsp_done),
  .ide_addr    (ide_addr),
  .ide_addr_en (ide_addr_en),
  .ide_rd_n    (ide_rd_n),
  .ide_wr_n    (ide_wr_n),
  .ide_dout_en (ide_dout_en)
);

// File: tb/ide_pio_seq_bench.sv
module ide_pio_seq_bench;

  localparam int AW = 5;
  localparam int DW = 16;
  localparam int NSTRB = 3;

  typedef struct {
    logic [DW-1:0] din;
    logic          ready, aen, rdn, wrn, oen, done;
    logic          chk_addr, chk_dout, chk_rd;
    logic [AW-1:0] addr;
    logic [DW-1:0] dout, rdata;
    string         tag;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] ide_addr;
  logic          ide_addr_en, ide_rd_n, ide_wr_n, ide_dout_en;
  logic [DW-1:0] ide_dout, ide_din;

  exp_t q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   fin    = 0;
  bit   jtog   = 0;

  ide_pio_seq #(.ADDR_W(AW), .DATA_W(DW), .STRB_STEPS(NSTRB)) u_ide_pio_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ide_addr(ide_addr),
    .ide_addr_en(ide_addr_en), .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n),
    .ide_dout_en(ide_dout_en), .ide_dout(ide_dout), .ide_din(ide_din)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic exp_t idle_e();
    exp_t e;
    e.din = '0; e.ready = 1; e.aen = 0; e.rdn = 1; e.wrn = 1; e.oen = 0;
    e.done = 0; e.chk_addr = 0; e.chk_dout = 0; e.chk_rd = 0;
    e.addr = '0; e.dout = '0; e.rdata = '0; e.tag = "R1";
    return e;
  endfunction

  task automatic finish_up();
    if (!fin) begin
      fin = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic compare(exp_t e);
    bit bad;
    bad = (req_ready !== e.ready) || (ide_addr_en !== e.aen) ||
          (ide_rd_n !== e.rdn) || (ide_wr_n !== e.wrn) ||
          (ide_dout_en !== e.oen) || (rsp_done !== e.done) ||
          (e.chk_addr && ide_addr !== e.addr) ||
          (e.chk_dout && ide_dout !== e.dout) ||
          (e.chk_rd && rsp_rdata !== e.rdata);
    n_run++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s t=%0t got rdy=%b aen=%b rd=%b wr=%b oen=%b done=%b addr=%h dout=%h rdata=%h exp rdy=%b aen=%b rd=%b wr=%b oen=%b done=%b addr=%h dout=%h rdata=%h",
               e.tag, $time, req_ready, ide_addr_en, ide_rd_n, ide_wr_n, ide_dout_en,
               rsp_done, ide_addr, ide_dout, rsp_rdata, e.ready, e.aen, e.rdn, e.wrn,
               e.oen, e.done, e.addr, e.dout, e.rdata);
    end
  endtask

  // one clock: sample outputs at the falling edge, then drive inputs
  task automatic cycle();
    exp_t e;
    bit   busy;
    @(negedge clk);
    busy = (q.size() > 0);
    e = busy ? q.pop_front() : idle_e();
    ide_din = e.din;
    compare(e);
    jtog = ~jtog;
    // R2 R9: junk requests while busy must not disturb the transfer
    req_valid = busy & jtog;
    req_write = jtog;
    req_addr  = ~req_addr;
    req_wdata = ~req_wdata;
  endtask

  task automatic push_op(bit w, logic [AW-1:0] a, logic [DW-1:0] wd, logic [DW-1:0] rw);
    exp_t e;
    e = idle_e(); e.ready = 0; e.aen = 1; e.chk_addr = 1; e.addr = a; e.din = ~rw;
    e.tag = "R3"; q.push_back(e);
    e = idle_e(); e.ready = 0; e.chk_addr = 1; e.addr = a; e.din = ~rw;
    if (w) begin e.oen = 1; e.chk_dout = 1; e.dout = wd; e.tag = "R6"; end
    else e.tag = "R4";
    q.push_back(e);
    for (int k = 0; k < NSTRB; k++) begin
      e = idle_e(); e.ready = 0; e.chk_addr = 1; e.addr = a;
      e.din = (k == NSTRB - 1) ? rw : (rw ^ DW'(16'h1111 * (k + 1)));
      if (w) begin e.wrn = 0; e.oen = 1; e.chk_dout = 1; e.dout = wd; e.tag = "R6"; end
      else begin e.rdn = 0; e.tag = "R4"; end
      q.push_back(e);
    end
    e = idle_e(); e.ready = 0; e.chk_addr = 1; e.addr = a; e.din = ~rw; e.tag = "R7";
    q.push_back(e);
    e = idle_e(); e.ready = 0; e.done = 1; e.din = ~rw;
    if (!w) begin e.chk_rd = 1; e.rdata = rw; e.tag = "R5"; end
    else e.tag = "R7";
    q.push_back(e);
  endtask

  task automatic issue(bit w, logic [AW-1:0] a, logic [DW-1:0] wd, logic [DW-1:0] rw);
    while (q.size() > 0) cycle();
    cycle();
    req_valid = 1; req_write = w; req_addr = a; req_wdata = wd;
    push_op(w, a, wd, rw);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    ide_din = '0;
    repeat (3) begin
      @(negedge clk);
      compare(idle_e());   // R1 during reset
    end
    rst_n = 1;
    repeat (4) cycle();    // R1 idle after release
    issue(0, 5'h17, 16'h0000, 16'hA55A);  // read
    issue(1, 5'h03, 16'h1234, 16'h0000);  // write, back to back
    issue(1, 5'h1F, 16'hFFFF, 16'h0000);
    repeat (3) cycle();
    issue(0, 5'h00, 16'h0000, 16'h0000);  // read of zero
    issue(0, 5'h0A, 16'h0000, 16'h8001);
    issue(1, 5'h11, 16'h5AA5, 16'h0000);
    issue(0, 5'h15, 16'h0000, 16'hFFFF);
    while (q.size() > 0) cycle();
    repeat (3) cycle();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL R7 watchdog: got hung run, expected completion");
      finish_up();
    end
  end

endmodule